// File: doc/BRIEF.md
# Write-Only Serial Configuration Slave

This block is a write-only slave on a two-wire serial bus: one clock line and one open-drain data line. It loads a 32-bit configuration word that feeds downstream control logic. Both bus lines are brought into the system clock domain through two-flop synchronizers. All edge, start and stop detection works on the synchronized copies, so the system clock must run at least eight times faster than the bus clock. No register can be read back over the bus.

A frame is a fixed block write of ten bytes. The first is the slave address byte, which must be `8'hD2`. Next come a command byte and a count byte, then seven data bytes. The command byte, the count byte and the first three data bytes are received and counted but are otherwise discarded. When the address matches, the last four data bytes are staged in shadow registers. The live word takes them only when a stop arrives after all ten bytes. Until then, the live word holds parameterised defaults with the reserved bits forced to zero.

The frame controller has five states:
- **IDLE**: waiting for a start condition.
- **SHIFT**: collecting eight bits, MSB first, on bus-clock rising edges.
- **ACK_WAIT**: the byte is complete; waiting for the bus clock to fall.
- **ACK_DRIVE**: holding the acknowledge (when it is due) through the ninth clock.
- **IGNORE**: the frame is full; all traffic is ignored until the next start.

The transitions are:
- A start moves any state to SHIFT and clears the byte count.
- A stop moves any state to IDLE.
- SHIFT goes to ACK_WAIT on the eighth rising edge.
- ACK_WAIT goes to ACK_DRIVE on the next falling edge.
- ACK_DRIVE goes on the next falling edge to SHIFT, or to IGNORE once ten bytes have arrived.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, `cfg_word` equals `DEFAULT_CFG & ~RSV_MASK` (defaults 32'h5A3C96E1 and 32'h80000300, so 32'h5A3C94E1).
- R2: A frame of ten bytes whose first byte is 8'hD2, with bits sent MSB first and sampled on bus-clock rising edges, loads the live word after its stop condition. Data byte 3 (the seventh byte) goes to `cfg_word[7:0]`, data byte 4 to `[15:8]`, data byte 5 to `[23:16]` and data byte 6 to `[31:24]`.
- R3: The values of the command byte, the count byte and data bytes 0 to 2 have no effect on `cfg_word`.
- R4: A frame whose first byte is not 8'hD2 gets no acknowledge on any byte and leaves `cfg_word` unchanged.
- R5: `sda_pull` is 1 only through the ninth bus clock of a byte, and only if the address matched and the byte is one of the first ten of the frame.
- R6: Bits set in `RSV_MASK` read 0 in `cfg_word` whatever value was written to them.
- R7: A frame that ends with a stop before ten bytes have arrived leaves `cfg_word` unchanged.
- R8: Bytes after the tenth are not acknowledged and are ignored. The following stop still loads the ten-byte frame.
- R9: A repeated start resets the byte position to the address byte. The interrupted frame loads nothing.
- R10: A start is a data fall while the clock is high, and a stop is a data rise while the clock is high. `cfg_word` changes only in response to a stop, never earlier in the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial bus clock line |
| sda_in | input | 1 | Serial bus data line, as seen on the wire |
| sda_pull | output | 1 | 1 pulls the data line low (acknowledge) |
| cfg_word | output | 32 | Live configuration word |

## Verification
Every cycle, the assertions check the following:
- the acknowledge drive appears only after a matched address;
- the byte position never goes past ten;
- a stop always returns the controller to IDLE;
- a start always restarts at the address position;
- the live word stays still unless a commit occurs, and a commit loads exactly the masked shadow contents.

Only the bench scenarios can show the rest, by comparison with the reference model:
- which bytes land in which field;
- that overhead and discarded bytes are ignored;
- that mismatched, short, over-long and restarted frames give the right acknowledges and the right final word.

// File: rtl/cfg_slave_pkg.sv
package cfg_slave_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACK_WAIT,
        ST_ACK_DRIVE,
        ST_IGNORE
    } slv_state_t;
endpackage

// File: rtl/cfg_line_sync.sv
module cfg_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_in,
    output logic [LINES-1:0] cur_out,
    output logic [LINES-1:0] prv_out
);
    generate
        for (genvar l = 0; l < LINES; l++) begin : g_line
            logic [STAGES-1:0] chain;
            logic              prv;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '1;
                    prv   <= 1'b1;
                end else begin
                    chain <= {chain[STAGES-2:0], raw_in[l]};
                    prv   <= chain[STAGES-1];
                end
            end
            assign cur_out[l] = chain[STAGES-1];
            assign prv_out[l] = prv;
        end
    endgenerate
endmodule

// File: rtl/cfg_frame_fsm.sv
module cfg_frame_fsm
    import cfg_slave_pkg::*;
#(
    parameter logic [7:0] ADDR_BYTE   = 8'hD2,
    parameter int         FRAME_BYTES = 10,
    parameter int         FIRST_LIVE  = 6,
    parameter int         CFG_BYTES   = 4,
    localparam int        CW          = $clog2(FRAME_BYTES + 1),
    localparam int        IW          = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_ev,
    input  logic          stop_ev,
    input  logic          sda_bit,
    output logic          sda_pull,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [7:0]    wr_data,
    output logic          commit
);
    localparam logic [CW-1:0] FULL_CNT  = CW'(FRAME_BYTES);
    localparam logic [CW-1:0] FIRST_CNT = CW'(FIRST_LIVE);

    slv_state_t    state, state_nx;
    logic [2:0]    bit_cnt;
    logic [7:0]    shreg;
    logic [CW-1:0] rx_cnt;
    logic          addr_ok;
    logic          ack_en;
    logic          byte_done;
    logic [7:0]    full_byte;

    assign full_byte = {shreg[6:0], sda_bit};
    assign byte_done = (state == ST_SHIFT) && scl_rise && (bit_cnt == 3'd7);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (start_ev) begin
            state_nx = ST_SHIFT;
        end else if (stop_ev) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_SHIFT:     if (byte_done) state_nx = ST_ACK_WAIT;
                ST_ACK_WAIT:  if (scl_fall) state_nx = ST_ACK_DRIVE;
                ST_ACK_DRIVE: if (scl_fall) state_nx = (rx_cnt == FULL_CNT) ? ST_IGNORE : ST_SHIFT;
                ST_IGNORE:    state_nx = ST_IGNORE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            rx_cnt  <= '0;
            addr_ok <= 1'b0;
            ack_en  <= 1'b0;
        end else if (start_ev) begin
            bit_cnt <= '0;
            rx_cnt  <= '0;
            addr_ok <= 1'b0;
            ack_en  <= 1'b0;
        end else if (stop_ev) begin
            bit_cnt <= '0;
            rx_cnt  <= '0;
            addr_ok <= 1'b0;
            ack_en  <= 1'b0;
        end else begin
            if (state == ST_SHIFT && scl_rise) begin
                shreg   <= full_byte;
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (byte_done) begin
                rx_cnt <= rx_cnt + CW'(1);
                if (rx_cnt == '0) begin
                    addr_ok <= (full_byte == ADDR_BYTE);
                    ack_en  <= (full_byte == ADDR_BYTE);
                end else begin
                    ack_en  <= addr_ok;
                end
            end
            if (state == ST_ACK_DRIVE && scl_fall) begin
                bit_cnt <= '0;
                ack_en  <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        sda_pull = (state == ST_ACK_DRIVE) && ack_en;
        wr_en    = byte_done && addr_ok && (rx_cnt >= FIRST_CNT) && (rx_cnt < FULL_CNT);
        wr_idx   = IW'(rx_cnt - FIRST_CNT);
        wr_data  = full_byte;
        commit   = stop_ev && !start_ev && (rx_cnt == FULL_CNT) && addr_ok;
    end

    a_r5_pull_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> addr_ok);
    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= FULL_CNT);
    a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ev && !start_ev) |=> (state == ST_IDLE));
    a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_SHIFT && rx_cnt == '0));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
    parameter int   CFG_BYTES   = 4,
    parameter logic [8*CFG_BYTES-1:0] DEFAULT_CFG = '0,
    parameter logic [8*CFG_BYTES-1:0] RSV_MASK    = '0,
    localparam int  WW          = 8 * CFG_BYTES,
    localparam int  IW          = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic          commit,
    output logic [WW-1:0] cfg_word
);
    logic [WW-1:0] shadow_flat;

    generate
        for (genvar k = 0; k < CFG_BYTES; k++) begin : g_byte
            logic [7:0] shadow_q;
            logic [7:0] live_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shadow_q <= '0;
                    live_q   <= DEFAULT_CFG[k*8 +: 8] & ~RSV_MASK[k*8 +: 8];
                end else begin
                    if (wr_en && wr_idx == IW'(k)) shadow_q <= wr_data;
                    if (commit) live_q <= shadow_q & ~RSV_MASK[k*8 +: 8];
                end
            end
            assign shadow_flat[k*8 +: 8] = shadow_q;
            assign cfg_word[k*8 +: 8]    = live_q;
        end
    endgenerate

    a_r10_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cfg_word));
    a_r2_commit_loads_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (cfg_word == ($past(shadow_flat) & ~RSV_MASK)));
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
    parameter logic [7:0]  ADDR_BYTE   = 8'hD2,
    parameter int          FRAME_BYTES = 10,
    parameter int          FIRST_LIVE  = 6,
    parameter int          CFG_BYTES   = 4,
    parameter logic [31:0] DEFAULT_CFG = 32'h5A3C_96E1,
    parameter logic [31:0] RSV_MASK    = 32'h8000_0300
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        sda_pull,
    output logic [31:0] cfg_word
);
    localparam int IW = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1;

    logic [1:0]    cur, prv;
    logic          scl_rise, scl_fall, start_ev, stop_ev;
    logic          wr_en, commit;
    logic [IW-1:0] wr_idx;
    logic [7:0]    wr_data;

    cfg_line_sync #(.LINES(2), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in({scl_in, sda_in}),
        .cur_out(cur), .prv_out(prv)
    );

    // cur[1]/prv[1] = clock line, cur[0]/prv[0] = data line
    assign scl_rise = cur[1] & ~prv[1];
    assign scl_fall = ~cur[1] & prv[1];
    assign start_ev = cur[1] & prv[1] & prv[0] & ~cur[0];
    assign stop_ev  = cur[1] & prv[1] & ~prv[0] & cur[0];

    cfg_frame_fsm #(
        .ADDR_BYTE(ADDR_BYTE), .FRAME_BYTES(FRAME_BYTES),
        .FIRST_LIVE(FIRST_LIVE), .CFG_BYTES(CFG_BYTES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev), .sda_bit(cur[0]),
        .sda_pull(sda_pull), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .commit(commit)
    );

    cfg_reg_bank #(
        .CFG_BYTES(CFG_BYTES), .DEFAULT_CFG(DEFAULT_CFG), .RSV_MASK(RSV_MASK)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .commit(commit), .cfg_word(cfg_word)
    );
endmodule

// File: tb/cfg_serial_slave_bench.sv
module cfg_serial_slave_bench;
    localparam int          CLK_PERIOD = 10;
    localparam int          QTR        = 4;
    localparam logic [31:0] DEF        = 32'h5A3C_96E1;
    localparam logic [31:0] RSV        = 32'h8000_0300;
    localparam logic [7:0]  ADDR       = 8'hD2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_pull;
    logic [31:0] cfg_word;
    wire         sda_line = sda_m & ~sda_pull;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int settle = 0;
    logic [31:0] exp_cfg = DEF & ~RSV;
    logic [7:0]  frame_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_serial_slave u_cfg_serial_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .cfg_word(cfg_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison of the live word against the model (R10)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (settle > 0) settle--;
            else chk("R10 per-clock cfg_word", cfg_word, exp_cfg);
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(QTR);
        scl_m = 1'b1; wq(QTR);
        sda_m = 1'b0; wq(QTR);
        scl_m = 1'b0; wq(QTR);
        frame_q.delete();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(QTR);
        scl_m = 1'b1; wq(QTR);
        if (frame_q.size() >= 10 && frame_q[0] == ADDR)
            exp_cfg = {frame_q[9], frame_q[8], frame_q[7], frame_q[6]} & ~RSV;
        settle = 8;
        sda_m = 1'b1; wq(4 * QTR);
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag);
        logic exp_ack;
        int pos;
        pos = frame_q.size();
        frame_q.push_back(b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(QTR);
            scl_m = 1'b1; wq(2 * QTR);
            scl_m = 1'b0; wq(QTR);
        end
        sda_m = 1'b1; wq(QTR);
        chk({tag, " R5 pull low before ninth clock"}, 32'(sda_pull),
            32'(frame_q[0] == ADDR && pos < 10));
        scl_m = 1'b1; wq(QTR);
        exp_ack = (frame_q[0] == ADDR) && (pos < 10);
        chk({tag, " R5 ack on ninth clock"}, 32'(sda_pull), 32'(exp_ack));
        wq(QTR);
        scl_m = 1'b0; wq(2 * QTR);
        chk({tag, " R5 ack released"}, 32'(sda_pull), 32'd0);
    endtask

    task automatic send_frame(input logic [7:0] a, input logic [7:0] c0, input logic [7:0] c1,
                              input logic [31:0] junk, input logic [31:0] data, input string tag);
        send_byte(a, tag); send_byte(c0, tag); send_byte(c1, tag);
        send_byte(junk[7:0], tag); send_byte(junk[15:8], tag); send_byte(junk[23:16], tag);
        send_byte(data[7:0], tag); send_byte(data[15:8], tag);
        send_byte(data[23:16], tag); send_byte(data[31:24], tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(2);
        // R1 reset defaults, R6 reserved cleared
        chk("R1 reset value", cfg_word, 32'h5A3C_94E1);
        chk("R5 no pull at reset", 32'(sda_pull), 32'd0);

        // R2 / R6 full matched frame
        bus_start();
        send_frame(ADDR, 8'h00, 8'h07, 32'h00FF_EE11, 32'hFFEE_FF44, "R2");
        chk("R10 no change before stop", cfg_word, 32'h5A3C_94E1);
        bus_stop();
        chk("R2 frame loaded", cfg_word, exp_cfg);
        chk("R6 reserved bits zero", cfg_word & RSV, 32'd0);
        chk("R2 byte map", cfg_word, 32'h7FEE_FC44);

        // R3 different overhead/discarded bytes, same data
        bus_start();
        send_frame(ADDR, 8'hA7, 8'h33, 32'h1234_5678, 32'h0102_0304, "R3");
        bus_stop();
        chk("R3 overhead ignored", cfg_word, 32'h0102_0004);

        // R4 address mismatch
        bus_start();
        send_frame(8'hD0, 8'h00, 8'h07, 32'h0, 32'hDEAD_BEEF, "R4");
        bus_stop();
        chk("R4 mismatch keeps word", cfg_word, 32'h0102_0004);

        // R7 short frame
        bus_start();
        send_byte(ADDR, "R7"); send_byte(8'h0, "R7"); send_byte(8'h7, "R7");
        send_byte(8'h1, "R7"); send_byte(8'h2, "R7"); send_byte(8'h3, "R7");
        send_byte(8'h55, "R7"); send_byte(8'h66, "R7");
        bus_stop();
        chk("R7 short frame no change", cfg_word, 32'h0102_0004);

        // R8 extra bytes after tenth
        bus_start();
        send_frame(ADDR, 8'h0, 8'h7, 32'h0, 32'h1122_3344, "R8");
        send_byte(8'hAA, "R8 extra");
        send_byte(8'hBB, "R8 extra");
        bus_stop();
        chk("R8 extra bytes ignored", cfg_word, 32'h1122_3044);

        // R9 repeated start mid-frame
        bus_start();
        send_byte(ADDR, "R9"); send_byte(8'h0, "R9"); send_byte(8'h7, "R9"); send_byte(8'h9, "R9");
        bus_start();
        send_frame(ADDR, 8'h0, 8'h7, 32'hCAFE_0000, 32'h6677_8899, "R9");
        bus_stop();
        chk("R9 restart frame loaded", cfg_word, 32'h6677_8899 & ~RSV);

        // R9 repeated start abandons a nearly complete frame
        bus_start();
        send_frame(ADDR, 8'h0, 8'h7, 32'h0, 32'hFFFF_FFFF, "R9b");
        frame_q.delete();
        bus_start();
        send_byte(ADDR, "R9b");
        bus_stop();
        chk("R9 abandoned frame not loaded", cfg_word, 32'h6677_8899 & ~RSV);

        wq(10);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule